// File: doc/BRIEF.md
# Two-Decade BCD Fractional Rate Multiplier

This block supplies the fractional part of a synthesizer division ratio. It counts divider cycles in periods of one hundred and, in each period, picks out as many of them as a two-digit BCD program value asks for. In each picked cycle it raises a single pulse that the modulus controller uses to lengthen that cycle by one prescaler count. The chosen cycles are scattered across the period rather than evenly spaced.

Each divider cycle is a run of prescaler cycles whose position arrives on `cnt_i`, qualified by `cyc_en_i`. The block decides one count ahead, in the enabled cycle at position 29, whether the current divider cycle gets a pulse. It drives the pulse in the enabled cycle at position 30. The program value is taken at the first divider cycle of each period and held for the whole period, so a host write never splits a period. Only even values from 0 to 98 are honoured. An odd value is rounded down, and a non-BCD value drops to the next lower valid even value.

Top module: `bcd_rate_mult`

## Requirements
- R1: After reset, `pulse_o` is low, and the first divider cycle counted is cycle 0 of a new period.
- R2: In every period of 100 divider cycles, the number of pulses on `pulse_o` equals the program value for each even BCD value from 2 to 98.
- R3: A program value of 0 gives no pulse in the period.
- R4: A valid BCD program value with an odd units digit (bit 0 set) acts as the value one lower. For example, 0x37 gives 36 pulses.
- R5: A units digit (bits 3:0) above 9 acts as tens*10+8. A tens digit (bits 7:4) above 9 acts as 98.
- R6: `prog_i` is sampled only at the enabled position-29 cycle of cycle 0 of a period. A change at any other time first takes effect in the following period.
- R7: `pulse_o` is high only in a cycle with `cyc_en_i`=1 and `cnt_i`=30. The pulse decision is made at the preceding enabled position-29 cycle.
- R8: Pulses inside a period are not evenly spaced. With value 20, the gaps between successive pulsed divider cycles are not all equal.
- R9: Cycles with `cyc_en_i`=0 do not advance the divider-cycle count and never drive `pulse_o`, even when a pulse is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en_i | input | 1 | Qualifies the current prescaler cycle |
| cnt_i | input | 5 | Prescaler-cycle position within the divider cycle |
| prog_i | input | 8 | Fraction program value, two BCD digits (tens in bits 7:4) |
| pulse_o | output | 1 | Fractional pulse to the modulus controller |

## Verification
The pulse count per period is measured for the values 0, 2, 50 and 98. This covers the empty case, the units-only case, a tens-only case and the case where both decades are nearly full, which separates errors in either decade's weighting from errors in the hand-over between the decades. The values 0x37, 0x4C and 0xA5 test the clamping of odd and non-BCD digits. A write in the middle of a period shows whether the program value is latched only at the period boundary. A period with disabled cycles inserted at positions 29 and 30 shows that frame counting and pulse emission respect the enable, and recording the pulsed cycle indices for value 20 shows that the spacing is uneven.

// File: rtl/bcd_rm_pkg.sv
package bcd_rm_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;
    localparam digit_t DIGIT_MAX = 4'd9;

    typedef struct packed {
        digit_t fine;    // divider cycles within a sweep of ten
        digit_t coarse;  // sweeps within a period
        digit_t w_tens;  // latched tens digit
        digit_t w_units; // latched units digit
        logic   armed;   // pulse pending for the current divider cycle
    } rm_state_t;
endpackage

// File: rtl/bcd_prog_clamp.sv
module bcd_prog_clamp
    import bcd_rm_pkg::*;
(
    input  logic [2*DIGIT_W-1:0] raw_i,
    output digit_t               tens_o,
    output digit_t               units_o
);
    digit_t raw_t, raw_u;
    assign raw_t = raw_i[2*DIGIT_W-1:DIGIT_W];
    assign raw_u = raw_i[DIGIT_W-1:0];

    always_comb begin
        if (raw_t > DIGIT_MAX) begin
            tens_o  = DIGIT_MAX;
            units_o = DIGIT_MAX - 4'd1;
        end else if (raw_u > DIGIT_MAX) begin
            tens_o  = raw_t;
            units_o = DIGIT_MAX - 4'd1;
        end else begin
            tens_o  = raw_t;
            units_o = {raw_u[DIGIT_W-1:1], 1'b0};
        end
    end

    always_comb begin
        if (!$isunknown(raw_i)) begin
            p_even_units_r4: assert (!units_o[0]);
            p_bcd_digits_r5: assert (units_o <= DIGIT_MAX && tens_o <= DIGIT_MAX);
        end
    end
endmodule

// File: rtl/bcd_decade_gate.sv
module bcd_decade_gate
    import bcd_rm_pkg::*;
#(
    parameter int MIX = 3  // stride coprime with ten, scrambles the order
) (
    input  digit_t count_i,
    input  digit_t weight_i,
    output logic   hit_o,
    output logic   last_o
);
    localparam int PW = 2 * DIGIT_W;
    logic [PW-1:0] prod;
    digit_t        rank;

    always_comb begin
        prod = PW'(count_i) * PW'(MIX);
        while_free_mod: begin
            if (prod >= PW'(20))      prod = prod - PW'(20);
            else if (prod >= PW'(10)) prod = prod - PW'(10);
        end
        rank   = prod[DIGIT_W-1:0];
        hit_o  = rank < weight_i;
        last_o = rank == DIGIT_MAX;
    end
endmodule

// File: rtl/bcd_rate_mult.sv
module bcd_rate_mult
    import bcd_rm_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int ARM_POS  = 29,
    parameter int EMIT_POS = 30,
    parameter int MIX      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cyc_en_i,
    input  logic [CNT_W-1:0]   cnt_i,
    input  logic [2*DIGIT_W-1:0] prog_i,
    output logic               pulse_o
);
    localparam logic [CNT_W-1:0] ARM_C  = CNT_W'(ARM_POS);
    localparam logic [CNT_W-1:0] EMIT_C = CNT_W'(EMIT_POS);

    rm_state_t st_q, st_d;
    digit_t    new_t, new_u, use_t, use_u;
    logic      step, emit, start;
    logic      fine_hit, fine_last, coarse_hit;

    bcd_prog_clamp u_clamp (
        .raw_i  (prog_i),
        .tens_o (new_t),
        .units_o(new_u)
    );

    assign step  = cyc_en_i && (cnt_i == ARM_C);
    assign emit  = cyc_en_i && (cnt_i == EMIT_C);
    assign start = (st_q.fine == '0) && (st_q.coarse == '0);
    assign use_t = start ? new_t : st_q.w_tens;
    assign use_u = start ? new_u : st_q.w_units;

    // Tens weight: compared every divider cycle against the fast counter.
    bcd_decade_gate #(.MIX(MIX)) u_fine (
        .count_i (st_q.fine),
        .weight_i(use_t),
        .hit_o   (fine_hit),
        .last_o  (fine_last)
    );

    // Units weight: one slot per sweep, the one the tens weight never claims.
    logic coarse_last_unused;
    bcd_decade_gate #(.MIX(MIX)) u_coarse (
        .count_i (st_q.coarse),
        .weight_i(use_u),
        .hit_o   (coarse_hit),
        .last_o  (coarse_last_unused)
    );

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (start) begin
                st_d.w_tens  = new_t;
                st_d.w_units = new_u;
            end
            st_d.armed = fine_hit || (fine_last && coarse_hit);
            if (st_q.fine == DIGIT_MAX) begin
                st_d.fine   = '0;
                st_d.coarse = (st_q.coarse == DIGIT_MAX) ? '0 : st_q.coarse + 4'd1;
            end else begin
                st_d.fine = st_q.fine + 4'd1;
            end
        end else if (emit) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.armed && emit;

    p_counters_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fine <= DIGIT_MAX && st_q.coarse <= DIGIT_MAX);
    p_arm_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.armed) |-> $past(cyc_en_i && cnt_i == ARM_C));
    p_disarm_after_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en_i && cnt_i == EMIT_C) |=> !st_q.armed);
    p_hold_program_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && start) |=> $stable({st_q.w_tens, st_q.w_units}));
    p_idle_no_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en_i |=> $stable({st_q.fine, st_q.coarse}));
    p_zero_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.w_tens == '0 && st_q.w_units == '0 && !start) |=> !$rose(st_q.armed));
endmodule

// File: tb/bcd_rate_mult_bench.sv
module bcd_rate_mult_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en_i = 1'b0;
    logic [4:0] cnt_i = '0;
    logic [7:0] prog_i = '0;
    logic       pulse_o;

    int n_checks = 0, n_fail = 0;
    int pulses, slot_bad, frame_idx;
    int pf [0:99];
    bit done = 0;

    always #4 clk = ~clk;

    bcd_rate_mult u_bcd_rate_mult (
        .clk(clk), .rst_n(rst_n), .cyc_en_i(cyc_en_i),
        .cnt_i(cnt_i), .prog_i(prog_i), .pulse_o(pulse_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int pos, input bit en);
        @(posedge clk); #1;
        cnt_i = 5'(pos); cyc_en_i = en;
        @(negedge clk);
        if (pulse_o) begin
            if (!(en && pos == 30)) slot_bad++;
            else begin
                if (pulses < 100) pf[pulses] = frame_idx;
                pulses++;
            end
        end
    endtask

    task automatic run_frames(input int n, input bit stall);
        for (int f = 0; f < n; f++) begin
            for (int p = 0; p < 32; p++) begin
                if (stall && (p == 29 || p == 30)) cyc(p, 1'b0);
                cyc(p, 1'b1);
            end
            frame_idx++;
        end
    endtask

    task automatic period(input logic [7:0] v, input int exp, input string req);
        prog_i = v; pulses = 0; slot_bad = 0; frame_idx = 0;
        run_frames(100, 1'b0);
        chk(pulses == exp, req, pulses, exp);
    endtask

    task automatic t_reset;
        cyc(30, 1'b1);
        chk(pulse_o == 1'b0, "R1 reset pulse low", int'(pulse_o), 0);
    endtask

    task automatic t_even_values;
        period(8'h00, 0, "R3 zero value");
        chk(slot_bad == 0, "R7 slot during zero", slot_bad, 0);
        period(8'h98, 98, "R2 value 98");
        chk(slot_bad == 0, "R7 slot at 98", slot_bad, 0);
        period(8'h50, 50, "R2 value 50");
        period(8'h02, 2, "R2 value 2");
        chk(slot_bad == 0, "R7 slot at 2", slot_bad, 0);
    endtask

    task automatic t_clamp;
        period(8'h37, 36, "R4 odd 0x37");
        period(8'h4C, 48, "R5 units 0x4C");
        period(8'hA5, 98, "R5 tens 0xA5");
    endtask

    task automatic t_spacing;
        bit uneven;
        period(8'h20, 20, "R8 count at 20");
        uneven = 0;
        for (int i = 2; i < 20; i++)
            if (pf[i] - pf[i-1] != pf[1] - pf[0]) uneven = 1;
        chk(uneven, "R8 uneven gaps", int'(uneven), 1);
    endtask

    task automatic t_midchange;
        prog_i = 8'h10; pulses = 0; frame_idx = 0;
        run_frames(50, 1'b0);
        prog_i = 8'h80;
        run_frames(50, 1'b0);
        chk(pulses == 10, "R6 held across write", pulses, 10);
        period(8'h80, 80, "R6 new value next period");
    endtask

    task automatic t_stall;
        prog_i = 8'h64; pulses = 0; slot_bad = 0; frame_idx = 0;
        run_frames(100, 1'b1);
        chk(pulses == 64, "R9 total with idle cycles", pulses, 64);
        chk(slot_bad == 0, "R9 no pulse on idle cycle", slot_bad, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        // cycle 0 of the first period is still ahead: reset again cleanly
        rst_n = 1'b0; #10; rst_n = 1'b1;
        t_even_values;
        t_clamp;
        t_spacing;
        t_midchange;
        t_stall;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule